// File: doc/BRIEF.md
# Indexed Clock Register Window with Event Status

This block is the host-facing register window of a real-time clock. The host sees two byte addresses. A write to the even address selects one of 128 byte locations. An access to the odd address then reads or writes the selected byte.

Four locations hold control and status. The first control register holds a rate field and an update-busy flag that the host cannot write. The second holds the interrupt enables and a hold bit that freezes time updates. The third holds the event flags and clears when it is read. The fourth is a fixed status byte. Every other location is plain byte storage, including the time and date bytes that an external counter also uses.

The counter, the divider and the alarm comparator live outside this block. They report periodic, alarm, update-start and update-end events as one-cycle pulses. In return, the block gives them a one-cycle reload strobe and the two control bytes. The event flags drive a level interrupt output. That output stays high until the host reads the flag register.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (bus_addr=0) stores bus_wdata[6:0] as the index, with bit 7 ignored. A read from the even address returns 0xFF.
- R2: An odd-address access (bus_addr=1) reads or writes the byte at the current index. Locations 0–9 and 14–127 hold any written byte unchanged.
- R3: Bit 7 of control register A (index 10) is the update-busy flag and ignores host writes. A write to A replaces bits 6:0 only.
- R4: A write to control register B (index 11) with bit 7 (hold) set stores the byte with bit 4 (update-end enable) forced to 0. The same write clears bit 7 of A.
- R5: Writes to the flag register (index 12) and the fixed status byte (index 13) leave both unchanged.
- R6: A read of the flag register returns its current value. The register then becomes 0x00 and irq falls, unless an event arrives in that same cycle.
- R7: After reset, A=0x26, B=0x02, flags=0x00, status byte=0x80, the index is 0 and irq is low.
- R8: time_reload pulses high for one cycle after either of these host writes:
  - a write to a time byte (index 0, 2, 4, 6, 7, 8 or 9) while hold is 0;
  - a write to B that changes hold from 1 to 0.
  Other writes leave time_reload low.
- R9: Each event, when its enable bit in B is set, ORs a value into the flags:
  - ev_periodic with B bit 6 ORs in 0xC0;
  - ev_alarm with B bit 5 ORs in 0xA0;
  - ev_update with B bit 4 ORs in 0x90.
  An event whose enable bit is clear changes nothing. irq follows flag bit 7.
- R10: When an enabled event and a flag-register read fall in the same cycle, the read returns the old value and the event's bits remain set afterwards, keeping irq high.
- R11: ev_upd_start sets A bit 7 only while hold is 0. ev_update clears A bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| ev_periodic | input | 1 | Periodic tick pulse from the divider |
| ev_alarm | input | 1 | Alarm match pulse from the comparator |
| ev_upd_start | input | 1 | Counter begins a time update |
| ev_update | input | 1 | Counter finished a time update |
| irq | output | 1 | Level interrupt request |
| time_reload | output | 1 | Pulse telling the counter to reload from the time bytes |
| ctl_a | output | 8 | Current control register A |
| ctl_b | output | 8 | Current control register B |

## Verification
The assertions assume that bus_sel, bus_wr, bus_addr and every event input are 0 or 1 at each clock edge. They also assume that write data is known whenever a write is strobed. The bench drives all inputs from the falling edge and returns them to 0 between accesses, so these assumptions hold. Events are applied as isolated one-cycle pulses. The only exception is the deliberate collision of an event with a flag-register read.

// File: rtl/rtc_regport.sv
module rtc_regport #(
  parameter int DW     = 8,
  parameter int IDX_W  = 7,
  parameter int A_INIT = 8'h26,
  parameter int B_INIT = 8'h02,
  parameter int D_INIT = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ev_periodic,
  input  logic          ev_alarm,
  input  logic          ev_upd_start,
  input  logic          ev_update,
  output logic          irq,
  output logic          time_reload,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] ctl_b
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IX_A = IDX_W'(10);
  localparam logic [IDX_W-1:0] IX_B = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_C = IDX_W'(12);
  localparam logic [IDX_W-1:0] IX_D = IDX_W'(13);

  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    reg_a, reg_b, reg_c;
  logic [DW-1:0]    ram [DEPTH];

  logic wr_odd, rd_odd, wr_even;
  logic wr_a, wr_b, rd_c, is_ctl, is_time, hold;
  logic [DW-1:0] ev_bits, c_next, b_wval;
  logic uip_next, reload_d;

  assign wr_even = bus_sel & bus_wr & ~bus_addr;
  assign wr_odd  = bus_sel & bus_wr & bus_addr;
  assign rd_odd  = bus_sel & ~bus_wr & bus_addr;
  assign wr_a    = wr_odd & (idx == IX_A);
  assign wr_b    = wr_odd & (idx == IX_B);
  assign rd_c    = rd_odd & (idx == IX_C);
  assign is_ctl  = (idx >= IX_A) && (idx <= IX_D);
  assign hold    = reg_b[7];

  always_comb begin
    case (idx)
      IDX_W'(0), IDX_W'(2), IDX_W'(4), IDX_W'(6),
      IDX_W'(7), IDX_W'(8), IDX_W'(9): is_time = 1'b1;
      default:                         is_time = 1'b0;
    endcase
  end

  always_comb begin
    ev_bits = '0;
    if (ev_periodic && reg_b[6]) ev_bits = ev_bits | DW'(8'hC0);
    if (ev_alarm    && reg_b[5]) ev_bits = ev_bits | DW'(8'hA0);
    if (ev_update   && reg_b[4]) ev_bits = ev_bits | DW'(8'h90);
  end

  assign c_next = (rd_c ? '0 : reg_c) | ev_bits;
  assign b_wval = bus_wdata[7] ? (bus_wdata & ~DW'(8'h10)) : bus_wdata;

  always_comb begin
    uip_next = reg_a[7];
    if (ev_upd_start && !hold) uip_next = 1'b1;
    if (ev_update || (wr_b && bus_wdata[7])) uip_next = 1'b0;
  end

  assign reload_d = (wr_odd & is_time & ~hold) | (wr_b & hold & ~bus_wdata[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx         <= '0;
      reg_a       <= DW'(A_INIT);
      reg_b       <= DW'(B_INIT);
      reg_c       <= '0;
      time_reload <= 1'b0;
    end else begin
      if (wr_even) idx <= bus_wdata[IDX_W-1:0];
      reg_a       <= {uip_next, wr_a ? bus_wdata[DW-2:0] : reg_a[DW-2:0]};
      if (wr_b) reg_b <= b_wval;
      reg_c       <= c_next;
      time_reload <= reload_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
    end else if (wr_odd && !is_ctl) begin
      ram[idx] <= bus_wdata;
    end
  end

  always_comb begin
    if (!bus_addr) bus_rdata = '1;
    else begin
      case (idx)
        IX_A:    bus_rdata = reg_a;
        IX_B:    bus_rdata = reg_b;
        IX_C:    bus_rdata = reg_c;
        IX_D:    bus_rdata = DW'(D_INIT);
        default: bus_rdata = ram[idx];
      endcase
    end
  end

  assign irq   = reg_c[7];
  assign ctl_a = reg_a;
  assign ctl_b = reg_b;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk #(parameter int DW = 8, parameter int IDX_W = 7) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic             bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             ev_periodic,
  input logic             ev_alarm,
  input logic             ev_upd_start,
  input logic             ev_update,
  input logic             irq,
  input logic             time_reload,
  input logic [DW-1:0]    ctl_a,
  input logic [DW-1:0]    ctl_b,
  input logic [IDX_W-1:0] idx,
  input logic [DW-1:0]    reg_c
);
  logic odd_wr, odd_rd, quiet;
  assign odd_wr = bus_sel && bus_wr && bus_addr;
  assign odd_rd = bus_sel && !bus_wr && bus_addr;
  assign quiet  = !ev_periodic && !ev_alarm && !ev_update && !ev_upd_start;

  AST_EVEN_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_addr) |-> bus_rdata == '1); // R1
  AST_BUSY_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_wr && idx == IDX_W'(10) && quiet) |=> ctl_a[7] == $past(ctl_a[7])); // R3
  AST_HOLD_DROPS_UIE: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_wr && idx == IDX_W'(11) && bus_wdata[7] && !ev_upd_start) |=> !ctl_b[4] && !ctl_a[7]); // R4
  AST_FLAGS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_wr && idx == IDX_W'(12) && quiet) |=> reg_c == $past(reg_c)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_rd && idx == IDX_W'(12) && quiet) |=> reg_c == '0 && !irq); // R6
  AST_ALARM_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_alarm && ctl_b[5]) |=> reg_c[7] && reg_c[5] && irq); // R9
  AST_EVENT_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_rd && idx == IDX_W'(12) && ev_update && ctl_b[4]) |=> reg_c[4] && irq); // R10
  AST_RELOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(time_reload) |-> $past(odd_wr)); // R8
endmodule

bind rtc_regport rtc_regport_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_upd_start(ev_upd_start),
  .ev_update(ev_update), .irq(irq), .time_reload(time_reload),
  .ctl_a(ctl_a), .ctl_b(ctl_b), .idx(idx), .reg_c(reg_c)
);

// File: tb/sim_rtc_regport.sv
module sim_rtc_regport;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = '0, bus_rdata, ctl_a, ctl_b;
  logic ev_periodic = 0, ev_alarm = 0, ev_upd_start = 0, ev_update = 0;
  logic irq, time_reload;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regport u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_upd_start(ev_upd_start),
    .ev_update(ev_update), .irq(irq), .time_reload(time_reload),
    .ctl_a(ctl_a), .ctl_b(ctl_b)
  );

  // {req[3:0], is_write, addr, data[7:0], expected[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 8'h8E, 8'h00},  // R1 index 14, bit 7 dropped
    {4'd2, 1'b1, 1'b1, 8'h5A, 8'h00},  // R2
    {4'd1, 1'b0, 1'b0, 8'h00, 8'hFF},  // R1 even read
    {4'd2, 1'b0, 1'b1, 8'h00, 8'h5A},  // R2
    {4'd1, 1'b1, 1'b0, 8'h7F, 8'h00},  // R1
    {4'd2, 1'b1, 1'b1, 8'hC3, 8'h00},  // R2
    {4'd2, 1'b0, 1'b1, 8'h00, 8'hC3},  // R2 top location
    {4'd2, 1'b1, 1'b0, 8'h01, 8'h00},  // R2 alarm byte
    {4'd2, 1'b1, 1'b1, 8'h3C, 8'h00},
    {4'd2, 1'b0, 1'b1, 8'h00, 8'h3C},  // R2
    {4'd3, 1'b1, 1'b0, 8'h0A, 8'h00},  // R3
    {4'd3, 1'b1, 1'b1, 8'hFF, 8'h00},
    {4'd3, 1'b0, 1'b1, 8'h00, 8'h7F},  // R3 busy bit untouched
    {4'd5, 1'b1, 1'b0, 8'h0D, 8'h00},  // R5
    {4'd5, 1'b1, 1'b1, 8'h00, 8'h00},
    {4'd5, 1'b0, 1'b1, 8'h00, 8'h80},  // R5 status byte fixed
    {4'd5, 1'b1, 1'b0, 8'h0C, 8'h00},
    {4'd5, 1'b1, 1'b1, 8'hFF, 8'h00},
    {4'd5, 1'b0, 1'b1, 8'h00, 8'h00},  // R5 flags not writable
    {4'd4, 1'b1, 1'b0, 8'h0B, 8'h00},  // R4
    {4'd4, 1'b1, 1'b1, 8'h92, 8'h00},
    {4'd4, 1'b0, 1'b1, 8'h00, 8'h82},  // R4 update-end enable forced off
    {4'd4, 1'b1, 1'b1, 8'h12, 8'h00},
    {4'd4, 1'b0, 1'b1, 8'h00, 8'h12}   // R4 enable kept when hold is 0
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_addr = 0;
  endtask

  task automatic rdi(input logic [7:0] ix, output logic [7:0] d);
    wr(0, ix); rd(1, d);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_periodic = 1; 1: ev_alarm = 1; 2: ev_upd_start = 1; default: ev_update = 1;
    endcase
    @(negedge clk);
    ev_periodic = 0; ev_alarm = 0; ev_upd_start = 0; ev_update = 0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7 reset state
    chk("R7 irq", {7'd0, irq}, 8'h00);
    rd(1, v);       chk("R7 index0", v, 8'h00);
    rdi(8'h0A, v);  chk("R7 A", v, 8'h26);
    rdi(8'h0B, v);  chk("R7 B", v, 8'h02);
    rdi(8'h0C, v);  chk("R7 C", v, 8'h00);
    rdi(8'h0D, v);  chk("R7 D", v, 8'h80);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) wr(VEC[i][16], VEC[i][15:8]);
      else begin
        rd(VEC[i][16], v);
        chk($sformatf("R%0d vec%0d", VEC[i][21:18], i), v, VEC[i][7:0]);
      end
    end

    // R9 event flags and enables
    wr(0, 8'h0A); wr(1, 8'h26);
    wr(0, 8'h0B); wr(1, 8'h02);
    pulse(1); pulse(0); pulse(3);
    chk("R9 disabled irq", {7'd0, irq}, 8'h00);
    rdi(8'h0C, v); chk("R9 disabled flags", v, 8'h00);
    wr(0, 8'h0B); wr(1, 8'h32);
    pulse(1);
    chk("R9 alarm irq", {7'd0, irq}, 8'h01);
    pulse(3);
    wr(0, 8'h0C); rd(1, v); chk("R9 accumulate", v, 8'hB0);
    // R6 cleared by read
    chk("R6 irq low", {7'd0, irq}, 8'h00);
    rd(1, v); chk("R6 flags zero", v, 8'h00);
    // R10 event in same cycle as read
    wr(0, 8'h0B); wr(1, 8'h42);
    wr(0, 8'h0C);
    @(negedge clk); bus_sel = 1; bus_addr = 1; ev_periodic = 1;
    #1 v = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_addr = 0; ev_periodic = 0;
    chk("R10 old value", v, 8'h00);
    chk("R10 irq kept", {7'd0, irq}, 8'h01);
    rd(1, v); chk("R10 bits kept", v, 8'hC0);

    // R11 busy flag
    wr(0, 8'h0B); wr(1, 8'h02);
    pulse(2); rdi(8'h0A, v); chk("R11 set", v, 8'hA6);
    wr(1, 8'h00); rd(1, v); chk("R3 busy kept on write", v, 8'h80);
    wr(1, 8'h26);
    pulse(3); rd(1, v); chk("R11 cleared", v, 8'h26);
    pulse(2);
    wr(0, 8'h0B); wr(1, 8'h82);
    rdi(8'h0A, v); chk("R4 busy cleared by hold", v, 8'h26);
    pulse(2); rd(1, v); chk("R11 hold blocks", v, 8'h26);

    // R8 reload strobe
    wr(0, 8'h02); wr(1, 8'h45);
    chk("R8 held write", {7'd0, time_reload}, 8'h00);
    wr(0, 8'h0B); wr(1, 8'h02);
    chk("R8 hold release", {7'd0, time_reload}, 8'h01);
    @(negedge clk); chk("R8 one cycle", {7'd0, time_reload}, 8'h00);
    wr(0, 8'h09); wr(1, 8'h24);
    chk("R8 time write", {7'd0, time_reload}, 8'h01);
    wr(0, 8'h01); wr(1, 8'h30);
    chk("R8 alarm byte", {7'd0, time_reload}, 8'h00);
    wr(0, 8'h14); wr(1, 8'h30);
    chk("R8 ram byte", {7'd0, time_reload}, 8'h00);

    done = 1;
    summary();
  end
endmodule